// File: doc/BRIEF.md
# Convolutional Byte Interleaver with Run-Time Depth

This block spreads a stream of payload bytes over time. A burst of line errors then lands on many different Reed-Solomon blocks once the far end reorders the bytes. Each valid input byte is handed to one of 33 branches in rotation. Branch k holds its bytes back for M*k of its own visits before they reappear. The bytes leaving the branches are merged into one output stream, in the order the inputs arrived, one clock after each input.

The depth M is chosen at run time, from 0 to 31. A value of 0 turns the block into a plain one-cycle register stage. A new depth is taken up only at a frame-boundary strobe that arrives while the rotation points at branch 0. When the depth really changes, the delay lines are treated as empty. Until real data has filled a branch, that branch delivers zero bytes.

Delay storage is an internal array. Each branch owns its own region of the array with its own circular pointer. The parameter `DEPTH_MAX` sets how deep the array is built. A full-range instance sets it to 31, which gives 16368 bytes. Requests above `DEPTH_MAX` are clamped to it. An interleaver paired with a matching deinterleaver delays data by 1056*M byte periods in total. Every channel that shares frame alignment must be given the same M.

Top module: `conv_byte_interleaver`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` and `out_byte` are 0, the active depth is 0 and the rotation points at branch 0.
- R2: Each valid input byte advances the rotation by one branch, wrapping from branch 32 back to branch 0. A byte routed to branch 0 appears unchanged at the output.
- R3: With active depth M > 0, a byte written on branch k (1..32) is output on the M*k-th later visit to branch k. Each visit returns that branch's byte from M*k visits before.
- R4: With active depth 0, every output byte equals the input byte of the previous cycle.
- R5: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_byte` is 0 whenever `out_valid` is low.
- R6: After the active depth changes, branch k outputs 8'h00 on its first M*k visits.
- R7: `depth_req` is loaded only on a clock edge where `frame_sync` is high and the rotation points at branch 0. A strobe at any other branch has no effect.
- R8: A request above `DEPTH_MAX` is taken as `DEPTH_MAX`. A load whose clamped value equals the active depth leaves the stored data untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Input payload byte |
| frame_sync | input | 1 | Frame-boundary strobe that allows a depth load |
| depth_req | input | 5 | Requested interleaving depth M (0..31) |
| out_valid | output | 1 | Output byte strobe, one cycle after `in_valid` |
| out_byte | output | 8 | Interleaved output byte |

## Verification
Every output result is due exactly one rising edge after the edge that samples its input byte. A depth load or flush takes effect on that same edge. The bench drives all inputs just after a falling edge and compares `out_valid` and `out_byte` at the next falling edge, half a period after the result is registered. The branch delay of R3 is counted in visits to a branch, not in clocks. The bench therefore keeps its own per-branch visit counts and history, so idle gaps between bytes do not shift the expected values.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int unsigned ILV_BRANCHES  = 33;
    localparam int unsigned ILV_BYTE_W    = 8;
    localparam int unsigned ILV_DEPTH_W   = 5;
    localparam int unsigned ILV_DEPTH_MAX = 3;

    // Sum of the branch indices below k: start of branch k's region, in units of M.
    function automatic int unsigned ilv_tri(input int unsigned k);
        return (k == 0) ? 0 : (k * (k - 1)) / 2;
    endfunction

endpackage

// File: rtl/ilv_commutator.sv
module ilv_commutator
    import ilv_pkg::*;
#(
    parameter  int unsigned BRANCHES  = ILV_BRANCHES,
    parameter  int unsigned DEPTH_W   = ILV_DEPTH_W,
    parameter  int unsigned DEPTH_MAX = ILV_DEPTH_MAX,
    localparam int unsigned BW        = $clog2(BRANCHES),
    localparam int unsigned RND_MAX   = DEPTH_MAX * (BRANCHES - 1),
    localparam int unsigned RW        = $clog2(RND_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               frame_sync,
    input  logic [DEPTH_W-1:0] depth_req,
    output logic [BW-1:0]      branch,
    output logic [DEPTH_W-1:0] depth,
    output logic [RW-1:0]      round,
    output logic               flush
);

    typedef struct packed {
        logic [BW-1:0]      branch;
        logic [DEPTH_W-1:0] depth;
        logic [RW-1:0]      round;
    } comm_t;

    comm_t              st_q, st_d;
    logic [DEPTH_W-1:0] req_eff;
    logic               load_en;

    always_comb begin
        req_eff = (depth_req > DEPTH_W'(DEPTH_MAX)) ? DEPTH_W'(DEPTH_MAX) : depth_req;
        load_en = frame_sync && (st_q.branch == '0);
        flush   = load_en && (req_eff != st_q.depth);
        st_d    = st_q;
        if (flush) begin
            st_d.depth = req_eff;
            st_d.round = '0;
        end
        if (in_valid) begin
            if (st_q.branch == BW'(BRANCHES - 1)) begin
                st_d.branch = '0;
                if (st_q.round != RW'(RND_MAX)) begin
                    st_d.round = st_q.round + 1'b1;
                end
            end else begin
                st_d.branch = st_q.branch + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign branch = st_q.branch;
    assign depth  = st_q.depth;
    assign round  = st_q.round;

    assert_branch_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.branch < BW'(BRANCHES));

    assert_branch_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && st_q.branch == BW'(BRANCHES - 1)) |=> (st_q.branch == '0));

    assert_branch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q.branch));

    assert_depth_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_sync && st_q.branch == '0) |=> $stable(st_q.depth));

    assert_depth_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.depth <= DEPTH_W'(DEPTH_MAX));

endmodule

// File: rtl/ilv_delay_store.sv
module ilv_delay_store
    import ilv_pkg::*;
#(
    parameter  int unsigned BRANCHES  = ILV_BRANCHES,
    parameter  int unsigned BYTE_W    = ILV_BYTE_W,
    parameter  int unsigned DEPTH_W   = ILV_DEPTH_W,
    parameter  int unsigned DEPTH_MAX = ILV_DEPTH_MAX,
    localparam int unsigned BW        = $clog2(BRANCHES),
    localparam int unsigned RND_MAX   = DEPTH_MAX * (BRANCHES - 1),
    localparam int unsigned RW        = $clog2(RND_MAX + 1),
    localparam int unsigned MEM_SZ    = DEPTH_MAX * ilv_tri(BRANCHES),
    localparam int unsigned AW        = $clog2(MEM_SZ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [BYTE_W-1:0]  in_byte,
    input  logic [BW-1:0]      branch,
    input  logic [DEPTH_W-1:0] depth,
    input  logic [RW-1:0]      round,
    input  logic               flush,
    output logic [BYTE_W-1:0]  rd_byte
);

    typedef struct packed {
        logic [BRANCHES-1:0][RW-1:0] ptr;
    } store_t;

    store_t            st_q, st_d;
    logic [BYTE_W-1:0] mem [MEM_SZ];
    logic [RW-1:0]     len, cur_ptr;
    logic [AW-1:0]     base, addr;
    logic              wr_en, stale;

    always_comb begin
        len     = RW'(depth) * RW'(branch);
        cur_ptr = st_q.ptr[branch];
        base    = AW'(depth) * AW'(ilv_tri(int'(branch)));
        addr    = base + AW'(cur_ptr);
        stale   = round < len;
        wr_en   = in_valid && (len != '0);
        if (len == '0) begin
            rd_byte = in_byte;
        end else if (stale) begin
            rd_byte = '0;
        end else begin
            rd_byte = mem[addr];
        end
        st_d = st_q;
        if (flush) begin
            st_d.ptr = '0;
        end else if (wr_en) begin
            st_d.ptr[branch] = (cur_ptr == len - 1'b1) ? '0 : cur_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= in_byte;
        end
    end

    assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (len != '0) |-> (cur_ptr < len));

    assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(addr) < MEM_SZ));

    assert_flush_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.ptr == '0));

endmodule

// File: rtl/conv_byte_interleaver.sv
module conv_byte_interleaver
    import ilv_pkg::*;
#(
    parameter int unsigned BRANCHES  = ILV_BRANCHES,
    parameter int unsigned BYTE_W    = ILV_BYTE_W,
    parameter int unsigned DEPTH_W   = ILV_DEPTH_W,
    parameter int unsigned DEPTH_MAX = ILV_DEPTH_MAX
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [BYTE_W-1:0]  in_byte,
    input  logic               frame_sync,
    input  logic [DEPTH_W-1:0] depth_req,
    output logic               out_valid,
    output logic [BYTE_W-1:0]  out_byte
);

    localparam int unsigned BW      = $clog2(BRANCHES);
    localparam int unsigned RND_MAX = DEPTH_MAX * (BRANCHES - 1);
    localparam int unsigned RW      = $clog2(RND_MAX + 1);

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } out_t;

    out_t               out_q, out_d;
    logic [BW-1:0]      branch_w;
    logic [DEPTH_W-1:0] depth_w;
    logic [RW-1:0]      round_w;
    logic               flush_w;
    logic [BYTE_W-1:0]  rd_byte_w;

    ilv_commutator #(
        .BRANCHES (BRANCHES),
        .DEPTH_W  (DEPTH_W),
        .DEPTH_MAX(DEPTH_MAX)
    ) comm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .frame_sync(frame_sync),
        .depth_req (depth_req),
        .branch    (branch_w),
        .depth     (depth_w),
        .round     (round_w),
        .flush     (flush_w)
    );

    ilv_delay_store #(
        .BRANCHES (BRANCHES),
        .BYTE_W   (BYTE_W),
        .DEPTH_W  (DEPTH_W),
        .DEPTH_MAX(DEPTH_MAX)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_byte (in_byte),
        .branch  (branch_w),
        .depth   (depth_w),
        .round   (round_w),
        .flush   (flush_w),
        .rd_byte (rd_byte_w)
    );

    always_comb begin
        out_d.valid = in_valid;
        out_d.data  = in_valid ? rd_byte_w : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign out_byte  = out_q.data;

    assert_out_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_out_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && out_byte == '0));

    assert_branch0_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && branch_w == '0) |=> (out_byte == $past(in_byte)));

    assert_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && depth_w == '0 && !flush_w) |=> (out_byte == $past(in_byte)));

endmodule

// File: tb/conv_byte_interleaver_tb_top.sv
module conv_byte_interleaver_tb_top;

    localparam int unsigned NB   = 33;
    localparam int unsigned DMAX = 3;
    localparam int unsigned HD   = 512;
    // Each row: requested depth, number of bytes in the phase.
    localparam int unsigned PHASES [6][2] = '{
        '{0, 70}, '{1, 165}, '{2, 264}, '{3, 330}, '{7, 132}, '{1, 99}
    };

    logic       clk        = 1'b0;
    logic       rst_n      = 1'b0;
    logic       in_valid   = 1'b0;
    logic [7:0] in_byte    = 8'h00;
    logic       frame_sync = 1'b0;
    logic [4:0] depth_req  = 5'd0;
    logic       out_valid;
    logic [7:0] out_byte;

    always #4 clk = ~clk;

    conv_byte_interleaver #(
        .BRANCHES (NB),
        .BYTE_W   (8),
        .DEPTH_W  (5),
        .DEPTH_MAX(DMAX)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .frame_sync(frame_sync),
        .depth_req (depth_req),
        .out_valid (out_valid),
        .out_byte  (out_byte)
    );

    int         n_checks  = 0;
    int         n_fail    = 0;
    int         exp_depth = 0;
    int         bb        = 0;
    int         cnt       = 0;
    int         vis [NB];
    logic [7:0] hist [NB][HD];
    string      ctx       = "";

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] nextb();
        cnt++;
        return 8'((cnt * 37 + 5) & 255);
    endfunction

    // Called just after a falling edge: drives one cycle, checks at the next falling edge.
    task automatic step(input bit v, input logic [7:0] d, input bit s, input int req);
        int         eff;
        int         len;
        logic [7:0] e;
        string      tag;
        in_valid   = v;
        in_byte    = d;
        frame_sync = s;
        depth_req  = 5'(req);
        eff = (req > int'(DMAX)) ? int'(DMAX) : req;
        if (s && bb == 0 && eff != exp_depth) begin
            exp_depth = eff;
            foreach (vis[i]) vis[i] = 0;
        end
        e   = 8'h00;
        tag = ctx;
        if (v) begin
            len = exp_depth * bb;
            if (len == 0) begin
                e = d;
                if (tag == "") tag = (bb == 0) ? "R2" : "R4";
            end else if (vis[bb] < len) begin
                e = 8'h00;
                if (tag == "") tag = "R6";
            end else begin
                e = hist[bb][vis[bb] - len];
                if (tag == "") tag = "R3";
            end
            if (vis[bb] < int'(HD)) hist[bb][vis[bb]] = d;
            vis[bb]++;
            bb = (bb + 1) % NB;
        end
        @(negedge clk);
        check(out_valid == v, "R5", int'(out_valid), int'(v));
        if (v) check(out_byte == e, tag, int'(out_byte), int'(e));
        else   check(out_byte == 8'h00, "R5", int'(out_byte), 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        summary();
        $finish;
    end

    initial begin
        foreach (vis[i]) vis[i] = 0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        check(out_byte == 8'h00, "R1", int'(out_byte), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);

        // First byte after reset must sit on branch 0 with depth 0.
        ctx = "R1";
        step(1'b1, nextb(), 1'b0, 0);
        ctx = "";

        for (int r = 0; r < 6; r++) begin
            int req = int'(PHASES[r][0]);
            int n   = int'(PHASES[r][1]);
            if (bb != 0) begin
                ctx = "R7";
                step(1'b1, nextb(), 1'b1, (req + 1) % 4);
                while (bb != 0) step(1'b1, nextb(), 1'b0, 0);
            end
            ctx = (req > int'(DMAX)) ? "R8" : "";
            step(1'b1, nextb(), 1'b1, req);
            for (int i = 1; i < n; i++) begin
                if (i % 7 == 0) step(1'b0, 8'h00, 1'b0, 0);
                step(1'b1, nextb(), 1'b0, 0);
            end
            ctx = "";
        end

        // Load on an idle cycle at branch 0: new depth, branches read as zero.
        ctx = "R6";
        step(1'b0, 8'h00, 1'b1, 2);
        for (int i = 0; i < 66; i++) step(1'b1, nextb(), 1'b0, 0);
        ctx = "";
        for (int i = 0; i < 99; i++) step(1'b1, nextb(), 1'b0, 0);

        // Oversized request clamps to the maximum and flushes from depth 2.
        while (bb != 0) step(1'b1, nextb(), 1'b0, 0);
        ctx = "R8";
        step(1'b1, nextb(), 1'b1, 31);
        for (int i = 1; i < 132; i++) step(1'b1, nextb(), 1'b0, 0);
        ctx = "";
        step(1'b0, 8'h00, 1'b0, 0);

        summary();
        $finish;
    end

endmodule